// File: doc/BRIEF.md
# GPIO Bank Controller with Per-Pin Interrupt Detection

This block controls one bank of general-purpose pins through a small word-addressed register bus. Software sets each pin's output value and output enable, reads the synchronized input level, and programs pad bias and a three-bit drive-strength code that the block passes straight to the pad ring. Every register keeps one bit per pin, and pin n always sits at bit n.

Each pin also has an interrupt detector. Three configuration bits choose how it senses: level or edge, a polarity bit (rising or active-high against falling or active-low), and a both-edges override for edge mode. A detected event sets a sticky raw status bit. A mask register gates that bit into a masked status view, and the OR of the masked bits forms the single interrupt output. Software acknowledges an event by writing ones to a clear register.

Inputs pass through a two-stage synchronizer. Edge detection then compares the synchronized sample with the one taken the cycle before. Reads are combinational on the address. Writes take effect at the clock edge on which the write strobe is high.

Top module: `gpio_bank_ctl`

## Requirements
- R1: After reset every register reads 0, and pin_out, pin_oe, pull_en, pull_up, drive_code and irq_out are all 0.
- R2: The word at 0x04 (output value) drives pin_out and the word at 0x08 (output enable, 1 = drive) drives pin_oe, bit n to pin n. Both read back what was written.
- R3: A read at 0x00 returns pin_in delayed by two clock edges through the synchronizer. Writes to 0x00 have no effect on the value read there.
- R4: With the level bit (0x0C) at 0, the both-edges bit (0x10) at 0 and the polarity bit (0x14) at 1, a rising input sets the pin's raw status bit (read at 0x1C) and a falling input does not. With polarity 0 the roles swap.
- R5: With the level bit at 0 and the both-edges bit at 1, rising and falling inputs both set the raw status bit, whatever the polarity bit holds.
- R6: With the level bit at 1, the raw status bit sets while the synchronized input equals the polarity bit (1 = active-high, 0 = active-low). A clear that meets an active level leaves the bit at 0 for exactly one cycle, after which it sets again.
- R7: The word at 0x20 reads as raw status AND the mask register (0x18, 1 = enabled), and irq_out is 1 exactly when that word is nonzero.
- R8: Writing to 0x24 clears each raw status bit written as 1 and leaves the bits written as 0 unchanged. A read at 0x24 returns 0. A raw status bit stays set until it is cleared.
- R9: The word at 0x38 drives pull_en (1 = bias on) and the word at 0x34 drives pull_up (1 = pull-up, 0 = pull-down). Both read back.
- R10: Drive strength is held as three bit planes at 0x58, 0x5C and 0x60, least significant plane first. Pin n's code, equal to mA/2 - 1, appears on drive_code[3n+2:3n], and each plane reads back.
- R11: The raw status bit sets whatever the mask holds. While the mask bit is 0 the event does not reach 0x20 or irq_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, sampled together with bus_en |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data, combinational on bus_addr |
| pin_in | input | NPINS | Pad input levels, asynchronous |
| pin_out | output | NPINS | Pad output values |
| pin_oe | output | NPINS | Pad output enables |
| pull_en | output | NPINS | Pad bias enables |
| pull_up | output | NPINS | Pad bias direction, 1 = up |
| drive_code | output | 3*NPINS | Drive-strength code per pin |
| irq_out | output | 1 | Combined masked interrupt |

## Verification
The bench targets the cases where one pin's mode interacts with another pin's state. It checks that a write-one-to-clear of one bit keeps a neighbouring pending bit; a design that clears the whole word would lose that event. It checks that a level-sensed pin re-asserts one cycle after a clear; a design that gives set priority would never show the gap, and one that latches the clear would miss the level that is still active. It checks that edges of the wrong polarity leave status alone, that a masked event still records raw status but keeps irq_out low, and that the input register lags the pin by exactly two edges, which exposes a missing or extra synchronizer stage.

// File: rtl/gpb_pkg.sv
// Shared constants for the GPIO bank: bus address width, register byte
// offsets and the number of drive-strength bit planes.
package gpb_pkg;
    localparam int ADDR_W = 8;
    localparam int DRV_W  = 3;
    localparam logic [ADDR_W-1:0] A_DIN    = 8'h00;
    localparam logic [ADDR_W-1:0] A_DOUT   = 8'h04;
    localparam logic [ADDR_W-1:0] A_OE     = 8'h08;
    localparam logic [ADDR_W-1:0] A_LVL    = 8'h0C;
    localparam logic [ADDR_W-1:0] A_DUAL   = 8'h10;
    localparam logic [ADDR_W-1:0] A_POL    = 8'h14;
    localparam logic [ADDR_W-1:0] A_MASK   = 8'h18;
    localparam logic [ADDR_W-1:0] A_RAW    = 8'h1C;
    localparam logic [ADDR_W-1:0] A_MSTAT  = 8'h20;
    localparam logic [ADDR_W-1:0] A_CLR    = 8'h24;
    localparam logic [ADDR_W-1:0] A_PSEL   = 8'h34;
    localparam logic [ADDR_W-1:0] A_PEN    = 8'h38;
    localparam logic [ADDR_W-1:0] A_DRV0   = 8'h58;
endpackage

// File: rtl/gpb_sync.sv
// Two-stage synchronizer for the asynchronous pad inputs.
// Assumes each bit is independent; no bus coherency is implied.
module gpb_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Shift the pad levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpb_irq_detect.sv
// Per-pin interrupt detector with sticky status.
// Edge mode compares the synchronized sample against last cycle's sample;
// level mode compares it against the polarity bit. Assumes smp is already
// synchronous. For level pins a clear wins over a new event in that cycle;
// for edge pins a new edge wins over a clear.
module gpb_irq_detect #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] smp,
    input  logic [N-1:0] cfg_lvl,
    input  logic [N-1:0] cfg_dual,
    input  logic [N-1:0] cfg_pol,
    input  logic [N-1:0] clr,
    output logic [N-1:0] status
);
    logic [N-1:0] prev_q, stat_q;
    logic [N-1:0] rise, fall, edge_hit, lvl_hit;

    // Classify the current sample for every pin.
    always_comb begin
        rise     = smp & ~prev_q;
        fall     = ~smp & prev_q;
        edge_hit = (cfg_dual & (rise | fall))
                 | (~cfg_dual & cfg_pol & rise)
                 | (~cfg_dual & ~cfg_pol & fall);
        lvl_hit  = ~(smp ^ cfg_pol);
    end

    // Keep last cycle's sample and update the sticky status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            stat_q <= '0;
        end else begin
            prev_q <= smp;
            stat_q <= (cfg_lvl & ~clr & (stat_q | lvl_hit))
                    | (~cfg_lvl & ((stat_q & ~clr) | edge_hit));
        end
    end

    assign status = stat_q;

    for (genvar i = 0; i < N; i++) begin : g_chk
        assert_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_lvl[i] && !cfg_dual[i] && cfg_pol[i] && smp[i] && !prev_q[i]) |=> stat_q[i]);
        assert_dual_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_lvl[i] && cfg_dual[i] && (smp[i] != prev_q[i])) |=> stat_q[i]);
        assert_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_lvl[i] && (smp[i] == cfg_pol[i]) && !clr[i]) |=> stat_q[i]);
        assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[i] && !clr[i]) |=> stat_q[i]);
        assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && (cfg_lvl[i] || (smp[i] == prev_q[i]))) |=> !stat_q[i]);
    end
endmodule

// File: rtl/gpb_regfile.sv
// Register file of the GPIO bank: holds all configuration words, decodes
// writes, produces the write-one-to-clear pulse and the read mux.
// Assumes word-aligned byte addresses; unmapped reads return 0.
module gpb_regfile
    import gpb_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_en,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [NPINS-1:0]        bus_wdata,
    output logic [NPINS-1:0]        bus_rdata,
    input  logic [NPINS-1:0]        din,
    input  logic [NPINS-1:0]        raw,
    output logic [NPINS-1:0]        dout,
    output logic [NPINS-1:0]        oe,
    output logic [NPINS-1:0]        lvl,
    output logic [NPINS-1:0]        dual,
    output logic [NPINS-1:0]        pol,
    output logic [NPINS-1:0]        mask,
    output logic [NPINS-1:0]        psel,
    output logic [NPINS-1:0]        pen,
    output logic [NPINS-1:0]        clr,
    output logic [DRV_W*NPINS-1:0]  drive_code
);
    logic wr;
    logic [NPINS-1:0] plane_q [DRV_W];

    assign wr  = bus_en && bus_we;
    assign clr = (wr && bus_addr == A_CLR) ? bus_wdata : '0;

    // Store the single-word configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0; oe  <= '0; lvl  <= '0; dual <= '0;
            pol  <= '0; mask <= '0; psel <= '0; pen <= '0;
        end else if (wr) begin
            case (bus_addr)
                A_DOUT: dout <= bus_wdata;
                A_OE:   oe   <= bus_wdata;
                A_LVL:  lvl  <= bus_wdata;
                A_DUAL: dual <= bus_wdata;
                A_POL:  pol  <= bus_wdata;
                A_MASK: mask <= bus_wdata;
                A_PSEL: psel <= bus_wdata;
                A_PEN:  pen  <= bus_wdata;
                default: ;
            endcase
        end
    end

    for (genvar k = 0; k < DRV_W; k++) begin : g_plane
        localparam logic [ADDR_W-1:0] PLANE_A = A_DRV0 + ADDR_W'(4 * k);
        // Store one drive-strength bit plane.
        always_ff @(posedge clk) begin
            if (!rst_n)                        plane_q[k] <= '0;
            else if (wr && bus_addr == PLANE_A) plane_q[k] <= bus_wdata;
        end
        for (genvar n = 0; n < NPINS; n++) begin : g_bit
            assign drive_code[n*DRV_W + k] = plane_q[k][n];
        end
    end

    // Select the word addressed by the bus.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_DIN:   bus_rdata = din;
            A_DOUT:  bus_rdata = dout;
            A_OE:    bus_rdata = oe;
            A_LVL:   bus_rdata = lvl;
            A_DUAL:  bus_rdata = dual;
            A_POL:   bus_rdata = pol;
            A_MASK:  bus_rdata = mask;
            A_RAW:   bus_rdata = raw;
            A_MSTAT: bus_rdata = raw & mask;
            A_PSEL:  bus_rdata = psel;
            A_PEN:   bus_rdata = pen;
            default: begin
                for (int k = 0; k < DRV_W; k++)
                    if (bus_addr == A_DRV0 + ADDR_W'(4 * k)) bus_rdata = plane_q[k];
            end
        endcase
    end
endmodule

// File: rtl/gpio_bank_ctl.sv
// Top of the GPIO bank: synchronizes the pad inputs, runs the per-pin
// interrupt detectors and exposes everything through the register file.
// Assumes NPINS equals the bus data width.
module gpio_bank_ctl
    import gpb_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_en,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [NPINS-1:0]        bus_wdata,
    output logic [NPINS-1:0]        bus_rdata,
    input  logic [NPINS-1:0]        pin_in,
    output logic [NPINS-1:0]        pin_out,
    output logic [NPINS-1:0]        pin_oe,
    output logic [NPINS-1:0]        pull_en,
    output logic [NPINS-1:0]        pull_up,
    output logic [DRV_W*NPINS-1:0]  drive_code,
    output logic                    irq_out
);
    logic [NPINS-1:0] smp, raw, lvl, dual, pol, mask, clr;

    gpb_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(smp)
    );

    gpb_irq_detect #(.N(NPINS)) u_det (
        .clk(clk), .rst_n(rst_n), .smp(smp), .cfg_lvl(lvl), .cfg_dual(dual),
        .cfg_pol(pol), .clr(clr), .status(raw)
    );

    gpb_regfile #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .din(smp), .raw(raw), .dout(pin_out), .oe(pin_oe), .lvl(lvl),
        .dual(dual), .pol(pol), .mask(mask), .psel(pull_up), .pen(pull_en),
        .clr(clr), .drive_code(drive_code)
    );

    assign irq_out = |(raw & mask);

    assert_irq_needs_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((mask != '0) && (raw != '0)));
    assert_masked_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq_out);
endmodule

// File: tb/gpio_bank_ctl_tb_top.sv
module gpio_bank_ctl_tb_top;
    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [NP-1:0] bus_wdata = '0, bus_rdata;
    logic [NP-1:0] pin_in = '0, pin_out, pin_oe, pull_en, pull_up;
    logic [3*NP-1:0] drive_code;
    logic          irq_out;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    gpio_bank_ctl #(.NPINS(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pull_en(pull_en), .pull_up(pull_up), .drive_code(drive_code),
        .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_pin(input int p, input logic v);
        @(negedge clk);
        pin_in[p] = v;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 8'h64; a += 4) begin
            rd(8'(a), v);
            check("R1 reg read", v, 32'h0);
        end
        check("R1 pin_out", pin_out, 0);
        check("R1 pin_oe", pin_oe, 0);
        check("R1 pull_en", pull_en, 0);
        check("R1 pull_up", pull_up, 0);
        check("R1 drive_code", {31'b0, |drive_code}, 0);
        check("R1 irq_out", {31'b0, irq_out}, 0);
    endtask

    task automatic t_output();
        logic [31:0] v;
        wr(8'h04, 32'hA5A5_0F0F);
        wr(8'h08, 32'hFFFF_0000);
        check("R2 pin_out", pin_out, 32'hA5A5_0F0F);
        check("R2 pin_oe", pin_oe, 32'hFFFF_0000);
        rd(8'h04, v); check("R2 out readback", v, 32'hA5A5_0F0F);
        rd(8'h08, v); check("R2 oe readback", v, 32'hFFFF_0000);
    endtask

    task automatic t_input();
        logic [31:0] v;
        @(negedge clk); pin_in = 32'h1234_5678;
        cycles(1); rd(8'h00, v); check("R3 one edge old", v, 32'h0);
        cycles(1); rd(8'h00, v); check("R3 two edges new", v, 32'h1234_5678);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); check("R3 write ignored", v, 32'h1234_5678);
        @(negedge clk); pin_in = '0;
        cycles(4);
        wr(8'h24, 32'hFFFF_FFFF);
        cycles(1);
        rd(8'h1C, v); check("R8 clear all", v, 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        wr(8'h14, 32'h0000_0008);
        set_pin(3, 1'b1); cycles(3);
        rd(8'h1C, v); check("R4 rising sets", v, 32'h0000_0008);
        wr(8'h24, 32'h0000_0008);
        rd(8'h1C, v); check("R8 cleared", v, 32'h0);
        set_pin(3, 1'b0); cycles(3);
        rd(8'h1C, v); check("R4 falling ignored at pol1", v, 32'h0);
        set_pin(4, 1'b1); cycles(3);
        rd(8'h1C, v); check("R4 rising ignored at pol0", v, 32'h0);
        set_pin(4, 1'b0); cycles(3);
        rd(8'h1C, v); check("R4 falling sets at pol0", v, 32'h0000_0010);
        wr(8'h24, 32'h0000_0010);
    endtask

    task automatic t_dual_w1c();
        logic [31:0] v;
        wr(8'h10, 32'h0000_0040);
        set_pin(6, 1'b1); cycles(3);
        rd(8'h1C, v); check("R5 dual rising", v, 32'h0000_0040);
        wr(8'h24, 32'h0000_0040);
        set_pin(6, 1'b0); cycles(3);
        rd(8'h1C, v); check("R5 dual falling", v, 32'h0000_0040);
        set_pin(3, 1'b1); cycles(3);
        rd(8'h1C, v); check("R8 two pending", v, 32'h0000_0048);
        wr(8'h24, 32'h0000_0008);
        cycles(2);
        rd(8'h1C, v); check("R8 zero bits kept", v, 32'h0000_0040);
        rd(8'h24, v); check("R8 clear reads zero", v, 32'h0);
        wr(8'h24, 32'hFFFF_FFFF);
    endtask

    task automatic t_level_mask();
        logic [31:0] v;
        wr(8'h14, 32'h0000_0028);
        wr(8'h0C, 32'h0000_0020);
        cycles(2);
        rd(8'h1C, v); check("R6 inactive level", v, 32'h0);
        set_pin(5, 1'b1); cycles(3);
        rd(8'h1C, v); check("R11 raw set while masked", v, 32'h0000_0020);
        rd(8'h20, v); check("R11 masked view zero", v, 32'h0);
        check("R11 irq low while masked", {31'b0, irq_out}, 0);
        wr(8'h18, 32'h0000_0020);
        rd(8'h20, v); check("R7 masked view", v, 32'h0000_0020);
        check("R7 irq high", {31'b0, irq_out}, 1);
        wr(8'h24, 32'h0000_0020);
        rd(8'h1C, v); check("R6 gap after clear", v, 32'h0);
        cycles(1);
        rd(8'h1C, v); check("R6 re-sets on active level", v, 32'h0000_0020);
        set_pin(5, 1'b0); cycles(3);
        rd(8'h1C, v); check("R8 level status sticky", v, 32'h0000_0020);
        wr(8'h24, 32'h0000_0020); cycles(1);
        rd(8'h1C, v); check("R6 stays clear when inactive", v, 32'h0);
        check("R7 irq low after clear", {31'b0, irq_out}, 0);
        wr(8'h14, 32'h0000_0008);
        cycles(2);
        rd(8'h1C, v); check("R6 active-low sets", v, 32'h0000_0020);
        wr(8'h0C, 32'h0);
        wr(8'h18, 32'h0);
        wr(8'h24, 32'hFFFF_FFFF);
    endtask

    task automatic t_pull();
        logic [31:0] v;
        wr(8'h38, 32'h0000_FFFF);
        wr(8'h34, 32'h00FF_00FF);
        check("R9 pull_en", pull_en, 32'h0000_FFFF);
        check("R9 pull_up", pull_up, 32'h00FF_00FF);
        rd(8'h34, v); check("R9 select readback", v, 32'h00FF_00FF);
    endtask

    task automatic t_drive();
        logic [31:0] v;
        wr(8'h58, 32'h0000_0001);
        wr(8'h5C, 32'h0000_0003);
        wr(8'h60, 32'h8000_0001);
        check("R10 pin0 code 16mA", {29'b0, drive_code[2:0]}, 32'd7);
        check("R10 pin1 code 6mA", {29'b0, drive_code[5:3]}, 32'd2);
        check("R10 pin31 code 10mA", {29'b0, drive_code[95:93]}, 32'd4);
        rd(8'h5C, v); check("R10 plane readback", v, 32'h0000_0003);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        cycles(3);
        @(negedge clk); rst_n = 1'b1;
        cycles(1);
        t_reset();
        t_output();
        t_input();
        t_edge();
        t_dual_w1c();
        t_level_mask();
        t_pull();
        t_drive();
        finished = 1;
        finish_run();
    end
endmodule